// File: doc/BRIEF.md
# Dual-Width Instruction Fetch and Field Expander

This block is the front end of a processor that runs either compact 16-bit instructions or widened 32-bit instructions. A status-register mode bit (`wide_mode`) selects which kind. The block keeps the program counter and issues longword-aligned reads on a 32-bit memory port. It waits for the data, extracts the next instruction and hands one uniform decoded record to the decoder.

A 32-bit instruction begins with the same halfword as its 16-bit counterpart, and its second halfword carries the extra field bits. A 16-bit instruction is widened by filling every added bit with zero. The decoder therefore sees one format in both modes. In 16-bit mode the upper half of the PC is frozen, so sequential flow and branches stay inside the current 64K page. In 32-bit mode the whole PC moves.

The memory request side and the decoded-instruction side are valid/ready streams. A request holds its address until `req_ready` is seen. The decoded record holds every field until `dec_ready` is seen. Only one read is outstanding at a time, and responses are always accepted. A redirect (`redirect_valid`) loads a new PC, discards any held instruction and any read in flight, and clears an alignment fault.

Top module: `dual_width_fetch`

## Requirements
- R1: After reset the PC equals the RESET_PC parameter. `req_valid` is high with `req_addr` equal to RESET_PC (longword aligned), and `dec_valid` and `align_fault` are low.
- R2: Every request address has bits 1:0 at zero and equals the PC with those two bits cleared. No new request is raised while a read is outstanding or a decoded instruction is held.
- R3: In 16-bit mode the longword's bits 31:16 form the instruction when PC bit 1 is 0, and bits 15:0 form it when PC bit 1 is 1.
- R4: The 16-bit expansion maps the instruction halfword as follows: bits 15:12 go to the opcode, 11:10 to source mode bits 1:0, 9:6 to source register bits 3:0, 5:4 to destination mode bits 1:0 and 3:0 to destination register bits 3:0. The source and destination mode bit 2, the register bit 4 and the size field are all zero.
- R5: In 32-bit mode bits 31:16 carry the same fields as R4. Bits 15, 14, 13 and 12 supply source mode bit 2, source register bit 4, destination mode bit 2 and destination register bit 4. Bits 11:10 form the size field (00 word, 01 byte, 10 longword). Bits 9:0 are ignored.
- R6: `dec_pc` is the address of the instruction delivered. After it is consumed, the PC advances by 4 in 32-bit mode. In 16-bit mode only the low 16 bits advance by 2, wrapping from 0xFFFE to 0x0000, and bits 31:16 stay unchanged.
- R7: If `wide_mode` is 1 while the PC has bit 1 set and a fetch is due, no request is made. `align_fault` rises on the next cycle and stays high, with no request and no output, until a redirect.
- R8: A redirect in 32-bit mode loads `redirect_pc` with bit 0 cleared. In 16-bit mode it loads only bits 15:1, clears bit 0 and keeps PC bits 31:16.
- R9: A redirect while a read is outstanding causes that read's response to be discarded. No decoded output comes from it, and the next request uses the new PC.
- R10: While `dec_valid` is high and `dec_ready` is low, with no redirect, all decoded outputs stay stable. While `req_valid` is high and `req_ready` is low, with no redirect, `req_addr` stays stable.
- R11: The width used to expand an instruction is the value of `wide_mode` when its request was accepted. A later change of the mode bit does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | Mode bit: 1 selects 32-bit instructions |
| redirect_valid | input | 1 | Load a new PC and flush |
| redirect_pc | input | ADDR_W | Redirect target |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Longword-aligned read address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data, bits 31:16 at the lower address |
| dec_valid | output | 1 | Decoded instruction valid |
| dec_ready | input | 1 | Decoder accepts the instruction |
| dec_opcode | output | 4 | Opcode |
| dec_src_mode | output | 3 | Source addressing mode |
| dec_src_reg | output | 5 | Source register |
| dec_dst_mode | output | 3 | Destination addressing mode |
| dec_dst_reg | output | 5 | Destination register |
| dec_size | output | 2 | Operand size |
| dec_pc | output | ADDR_W | Address of the delivered instruction |
| align_fault | output | 1 | Misaligned 32-bit fetch, held until redirect |

## Verification
The bench keeps ADDR_W and PAGE_W at 32 and 16 and sets RESET_PC to 0x0003_FFF8. The first 16-bit run therefore crosses the low-half wrap within a few instructions, with a non-zero page number that must survive the wrap. Random 32-bit redirect targets, together with 16-bit targets whose upper bits are random, show whether the page bits are kept or replaced. Read latency of up to five cycles leaves room for redirects and mode flips to land while a read is outstanding.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned OPC_W   = 4;
  localparam int unsigned MODE_W  = 3;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned SIZE_W  = 2;
  localparam int unsigned XBITS_W = 6;  // extension bits taken from the second halfword

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [MODE_W-1:0] src_mode;
    logic [REG_W-1:0]  src_reg;
    logic [MODE_W-1:0] dst_mode;
    logic [REG_W-1:0]  dst_reg;
    logic [SIZE_W-1:0] size;
  } dec_rec_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_FAULT = 2'd3
  } fetch_state_t;
endpackage

// File: rtl/dwf_pc.sv
module dwf_pc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAGE_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_en,
  input  logic [ADDR_W-1:0] redir_pc,
  input  logic              redir_wide,
  input  logic              adv_en,
  input  logic              adv_wide,
  output logic [ADDR_W-1:0] pc
);
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] pc_redir;
  logic [ADDR_W-1:0] pc_step;

  assign tgt = redir_pc & ~ADDR_W'(1);

  generate
    if (PAGE_W < ADDR_W) begin : g_paged
      // narrow mode: page number above PAGE_W is frozen
      assign pc_redir = redir_wide ? tgt : {pc[ADDR_W-1:PAGE_W], tgt[PAGE_W-1:0]};
      assign pc_step  = adv_wide ? pc + ADDR_W'(4)
                                 : {pc[ADDR_W-1:PAGE_W], pc[PAGE_W-1:0] + PAGE_W'(2)};

      a_r6_page_kept_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en && !adv_wide && !redir_en |=> $stable(pc[ADDR_W-1:PAGE_W]));
      a_r8_page_kept_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        redir_en && !redir_wide |=> $stable(pc[ADDR_W-1:PAGE_W]));
    end else begin : g_flat
      assign pc_redir = tgt;
      assign pc_step  = adv_wide ? pc + ADDR_W'(4) : pc + ADDR_W'(2);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc <= RESET_PC;
    else if (redir_en) pc <= pc_redir;
    else if (adv_en)   pc <= pc_step;
  end

  a_r8_even_after_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redir_en |=> !pc[0]);
endmodule

// File: rtl/dwf_expand.sv
module dwf_expand
  import dwf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              sel_low,
  input  logic              wide,
  output dec_rec_t          rec
);
  logic [HALF_W-1:0]  hw;
  logic [XBITS_W-1:0] xb;

  // first halfword sits in the upper bits; narrow mode may pick the lower one
  assign hw = (!wide && sel_low) ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];
  // widened bits come only from the second halfword, and only in wide mode
  assign xb = wide ? word[HALF_W-1:HALF_W-XBITS_W] : '0;

  always_comb begin
    rec.opc      = hw[15:12];
    rec.src_mode = {xb[5], hw[11:10]};
    rec.src_reg  = {xb[4], hw[9:6]};
    rec.dst_mode = {xb[3], hw[5:4]};
    rec.dst_reg  = {xb[2], hw[3:0]};
    rec.size     = xb[1:0];
  end

  always_comb begin
    if (!wide) begin
      a_r4_zero_fill: assert (rec.size == '0 && !rec.src_mode[2] && !rec.dst_mode[2]
                              && !rec.src_reg[4] && !rec.dst_reg[4]);
    end
  end
endmodule

// File: rtl/dual_width_fetch.sv
module dual_width_fetch
  import dwf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAGE_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_pc,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [OPC_W-1:0]  dec_opcode,
  output logic [MODE_W-1:0] dec_src_mode,
  output logic [REG_W-1:0]  dec_src_reg,
  output logic [MODE_W-1:0] dec_dst_mode,
  output logic [REG_W-1:0]  dec_dst_reg,
  output logic [SIZE_W-1:0] dec_size,
  output logic [ADDR_W-1:0] dec_pc,
  output logic              align_fault
);
  fetch_state_t      st_q, st_d;
  logic              drop_q, drop_d;
  logic              wide_q;
  logic [WORD_W-1:0] word_q;
  logic [ADDR_W-1:0] pc;
  dec_rec_t          rec;
  logic              misaligned;
  logic              accept;
  logic              advance;

  assign misaligned = wide_mode & pc[1];
  assign req_valid  = (st_q == ST_IDLE) & ~misaligned & ~redirect_valid;
  assign req_addr   = {pc[ADDR_W-1:2], 2'b00};
  assign accept     = req_valid & req_ready;
  assign advance    = (st_q == ST_HOLD) & dec_ready & ~redirect_valid;

  always_comb begin
    st_d   = st_q;
    drop_d = drop_q;
    if (redirect_valid) begin
      if (st_q == ST_WAIT && !rsp_valid) begin
        drop_d = 1'b1;               // read still owed: swallow it later
      end else begin
        st_d   = ST_IDLE;
        drop_d = 1'b0;
      end
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (misaligned)     st_d = ST_FAULT;
          else if (req_ready) st_d = ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            st_d   = drop_q ? ST_IDLE : ST_HOLD;
            drop_d = 1'b0;
          end
        end
        ST_HOLD:  if (dec_ready) st_d = ST_IDLE;
        ST_FAULT: st_d = ST_FAULT;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      drop_q <= 1'b0;
      wide_q <= 1'b0;
      word_q <= '0;
    end else begin
      st_q   <= st_d;
      drop_q <= drop_d;
      if (accept) wide_q <= wide_mode;
      if (st_q == ST_WAIT && rsp_valid) word_q <= rsp_data;
    end
  end

  dwf_pc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .redir_en   (redirect_valid),
    .redir_pc   (redirect_pc),
    .redir_wide (wide_mode),
    .adv_en     (advance),
    .adv_wide   (wide_q),
    .pc         (pc)
  );

  dwf_expand u_exp (
    .word    (word_q),
    .sel_low (pc[1]),
    .wide    (wide_q),
    .rec     (rec)
  );

  assign dec_valid    = (st_q == ST_HOLD);
  assign dec_opcode   = rec.opc;
  assign dec_src_mode = rec.src_mode;
  assign dec_src_reg  = rec.src_reg;
  assign dec_dst_mode = rec.dst_mode;
  assign dec_dst_reg  = rec.dst_reg;
  assign dec_size     = rec.size;
  assign dec_pc       = pc;
  assign align_fault  = (st_q == ST_FAULT);

  a_r10_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready && !redirect_valid |=>
      dec_valid && $stable(rec) && $stable(dec_pc));
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !redirect_valid |=> $stable(req_addr));
  a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> !req_valid && !dec_valid);
  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !req_valid);
  a_r9_drop_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_WAIT && drop_q && rsp_valid && !redirect_valid |=> !dec_valid);
  a_r11_width_held: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != ST_IDLE |=> $stable(wide_q));
endmodule

// File: tb/dual_width_fetch_bench.sv
module dual_width_fetch_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BENCH_RESET_PC = 32'h0003_FFF8;
  localparam int M_IDLE = 0, M_WAIT = 1, M_HOLD = 2, M_FAULT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        redirect_valid = 1'b0;
  logic [31:0] redirect_pc = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic [3:0]  dec_opcode;
  logic [2:0]  dec_src_mode;
  logic [4:0]  dec_src_reg;
  logic [2:0]  dec_dst_mode;
  logic [4:0]  dec_dst_reg;
  logic [1:0]  dec_size;
  logic [31:0] dec_pc;
  logic        align_fault;

  dual_width_fetch #(.RESET_PC(BENCH_RESET_PC)) u_dual_width_fetch (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_opcode(dec_opcode), .dec_src_mode(dec_src_mode), .dec_src_reg(dec_src_reg),
    .dec_dst_mode(dec_dst_mode), .dec_dst_reg(dec_dst_reg), .dec_size(dec_size),
    .dec_pc(dec_pc), .align_fault(align_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  // knobs
  int k_rdy = 100, k_dec = 100, k_lat = 0, k_redir = 0, k_flip = 0;
  bit k_wide = 0, k_auto = 0, force_redir = 0, release_now = 0, done = 0;
  logic [31:0] force_tgt = '0;
  // memory model
  bit pend = 0; logic [31:0] pend_a = '0; int pend_t = 0;
  // reference model
  int m_st = M_IDLE; bit m_drop = 0, f_mode = 0, since_redir = 0;
  logic [31:0] m_pc = BENCH_RESET_PC, m_buf = '0;
  // previous-cycle observations
  bit prev_dhold = 0, prev_rhold = 0;
  logic [53:0] prev_bundle = '0; logic [31:0] prev_addr = '0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return ((a ^ 32'h5A5A_0F0F) * 32'h0001_0003) ^ {a[15:0], a[31:16]};
  endfunction

  function automatic logic [21:0] expect_fields(input logic [31:0] w, input bit lo, input bit wide);
    logic [15:0] h; logic [5:0] x;
    h = (!wide && lo) ? w[15:0] : w[31:16];
    x = wide ? w[15:10] : 6'b0;
    return {h[15:12], x[5], h[11:10], x[4], h[9:6], x[3], h[5:4], x[2], h[3:0], x[1:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    bit exp_rv; logic [21:0] ef; logic [53:0] bundle; string t;
    bundle = {dec_pc, dec_opcode, dec_src_mode, dec_src_reg, dec_dst_mode, dec_dst_reg, dec_size};
    exp_rv = (m_st == M_IDLE) && !(wide_mode && m_pc[1]) && !redirect_valid;
    chk(req_valid == exp_rv, (wide_mode && m_pc[1]) ? "R7 request suppressed" : "R2 request valid",
        64'(req_valid), 64'(exp_rv));
    if (exp_rv)
      chk(req_addr == {m_pc[31:2], 2'b00}, since_redir ? "R8 redirect target" : "R2 fetch address",
          64'(req_addr), 64'({m_pc[31:2], 2'b00}));
    chk(align_fault == (m_st == M_FAULT), "R7 fault flag", 64'(align_fault), 64'(m_st == M_FAULT));
    chk(dec_valid == (m_st == M_HOLD), m_drop ? "R9 dropped read" : "R2 decoded valid",
        64'(dec_valid), 64'(m_st == M_HOLD));
    if (m_st == M_HOLD) begin
      ef = expect_fields(m_buf, m_pc[1], f_mode);
      if (f_mode != wide_mode) t = "R11 latched width";
      else if (f_mode) t = "R5 wide fields";
      else if (m_pc[1]) t = "R3 low halfword";
      else t = "R4 narrow fields";
      chk(bundle[21:0] == ef, t, 64'(bundle[21:0]), 64'(ef));
      chk(dec_pc == m_pc, "R6 instruction address", 64'(dec_pc), 64'(m_pc));
    end
    if (prev_dhold) chk(dec_valid && bundle == prev_bundle, "R10 decoded hold", 64'(bundle), 64'(prev_bundle));
    if (prev_rhold) chk(req_addr == prev_addr, "R10 request hold", 64'(req_addr), 64'(prev_addr));
    prev_dhold  = dec_valid && !dec_ready && !redirect_valid;
    prev_rhold  = req_valid && !req_ready && !redirect_valid;
    prev_bundle = bundle;
    prev_addr   = req_addr;
  endtask

  task automatic step_model();
    if (redirect_valid) begin
      m_pc = wide_mode ? {redirect_pc[31:1], 1'b0} : {m_pc[31:16], redirect_pc[15:1], 1'b0};
      since_redir = 1;
      if (m_st == M_WAIT && !rsp_valid) m_drop = 1;
      else begin m_st = M_IDLE; m_drop = 0; end
    end else begin
      case (m_st)
        M_IDLE: begin
          if (wide_mode && m_pc[1]) m_st = M_FAULT;
          else if (req_ready) begin m_st = M_WAIT; f_mode = wide_mode; since_redir = 0; end
        end
        M_WAIT: if (rsp_valid) begin
          if (m_drop) m_st = M_IDLE; else begin m_buf = rsp_data; m_st = M_HOLD; end
          m_drop = 0;
        end
        M_HOLD: if (dec_ready) begin
          m_pc = f_mode ? m_pc + 32'd4 : {m_pc[31:16], m_pc[15:0] + 16'd2};
          m_st = M_IDLE;
        end
        default: ;
      endcase
    end
  endtask

  task automatic step_memory();
    if (req_valid && req_ready) begin
      chk(!(pend && !rsp_valid), "R2 single outstanding", 64'(pend), 64'(0));
      pend = 1; pend_a = req_addr; pend_t = $urandom_range(k_lat);
    end else if (rsp_valid) pend = 0;
    else if (pend && pend_t > 0) pend_t--;
  endtask

  task automatic tick();
    @(negedge clk);
    rsp_valid = pend && (pend_t == 0);
    rsp_data  = rsp_valid ? mem_word(pend_a) : 32'h0;
    req_ready = ($urandom_range(99) < k_rdy);
    dec_ready = ($urandom_range(99) < k_dec);
    if (k_flip > 0 && $urandom_range(999) < k_flip) k_wide = ~k_wide;
    wide_mode = k_wide;
    redirect_valid = 1'b0;
    if (force_redir) begin
      redirect_valid = 1'b1; redirect_pc = force_tgt; force_redir = 0;
    end else if ((k_auto && m_st == M_FAULT) || ($urandom_range(999) < k_redir)) begin
      redirect_valid = 1'b1;
      redirect_pc = k_wide ? ($urandom() & 32'hFFFF_FFFC) : $urandom();
    end
    #1;
    if (release_now) begin
      release_now = 0;
      rst_n = 1'b1;
      #1;
      chk(req_valid == 1'b1, "R1 request after reset", 64'(req_valid), 64'(1));
      chk(req_addr == BENCH_RESET_PC, "R1 reset address", 64'(req_addr), 64'(BENCH_RESET_PC));
      chk(dec_valid == 1'b0, "R1 no decoded output", 64'(dec_valid), 64'(0));
      chk(align_fault == 1'b0, "R1 no fault", 64'(align_fault), 64'(0));
      prev_addr = req_addr;
    end else if (rst_n) check_outputs();
    if (rst_n) begin
      step_model();
      step_memory();
    end
  endtask

  initial begin
    repeat (3) tick();
    release_now = 1;
    tick();
    // narrow mode, no stalls: crosses the low-half wrap (R6)
    k_rdy = 100; k_dec = 100; k_lat = 0;
    repeat (40) tick();
    // narrow mode with back-pressure and latency (R3, R4, R10)
    k_rdy = 60; k_dec = 50; k_lat = 3;
    repeat (300) tick();
    // switch to wide mode with a full-width redirect (R5, R8)
    k_wide = 1; force_tgt = 32'h0001_0100; force_redir = 1;
    repeat (300) tick();
    // misaligned wide fetch: fault held until redirect (R7)
    force_tgt = 32'h0001_0202; force_redir = 1;
    repeat (8) tick();
    chk(align_fault == 1'b1 && req_valid == 1'b0, "R7 fault held", 64'({align_fault, req_valid}), 64'(2'b10));
    force_tgt = 32'h0002_0000; force_redir = 1;
    repeat (60) tick();
    // redirects landing on outstanding reads (R9, R8)
    k_auto = 1; k_redir = 80; k_lat = 5;
    repeat (500) tick();
    k_wide = 0;
    repeat (500) tick();
    // mode bit flipping while reads are outstanding (R11)
    k_flip = 60; k_redir = 20;
    repeat (1500) tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule